// File: doc/BRIEF.md
# Dependence-Aware Parallel Issue Scheduler

This block takes a window of up to `DEPTH` decoded instructions in program order and works out the cycle in which each one executes. Each entry carries an optional destination register and up to two optional source registers. Any implicit result register, such as a multiply high/low pair, is given its own register number by whoever fills the window. The number of functional units is taken to be unlimited. In every cycle the block issues all pending entries that no pending older entry blocks. Each instruction executes in one cycle and writes its result at the end of that cycle, so a dependent entry issues one cycle later at the earliest.

A pulse on `start_i` captures the window and the hazard rule. `full_mode_i` = 1 selects the rule where read-after-write, write-after-read and write-after-write pairs all block. `full_mode_i` = 0 selects the rule where only read-after-write pairs block. The block then issues entries one cycle per clock edge until none is pending. It reports one issue-cycle number per entry, numbered from 1, and raises `done_o` when the schedule is complete.

Top module: `sched_issue_window`

## Requirements
- R1: On the clock edge that samples `start_i` high, the block captures the window and the mode, clears every issue cycle to 0, and restarts the cycle count. After that edge `done_o` is low as long as any valid entry is pending.
- R2: Cycles are numbered from 1, and the number of issues per cycle has no limit. Mutually independent entries all report cycle 1.
- R3: A read-after-write pair blocks in both modes. An entry whose valid source equals the valid destination of an older pending entry issues one cycle after the last such writer.
- R4: With `full_mode_i`=1, an entry whose destination is a valid source of an older pending entry waits until that older entry has issued (write-after-read).
- R5: With `full_mode_i`=1, an entry whose destination equals the destination of an older pending entry waits until that older entry has issued (write-after-write).
- R6: With `full_mode_i`=0, write-after-read and write-after-write pairs never delay an entry.
- R7: Register 0 never forms a dependence. A source or destination whose own valid flag is clear forms no dependence.
- R8: An entry whose valid bit is clear reports issue cycle 0, forms no hazard and does not hold back `done_o`.
- R9: Once `done_o` is high, it and every issue cycle stay unchanged until the next start.
- R10: `done_o` rises exactly N clock edges after the start edge, where N is the largest reported issue cycle. For an empty window it is high right after the start edge.
- R11: An entry blocks younger entries only while it is still pending. Younger entries never delay older ones.
- R12: Entry encoding within `entries_i` (entry k at bits k*22 +: 22): bit 21 valid, bit 20 destination valid, bits 19:14 destination, bit 13 source A valid, bits 12:7 source A, bit 6 source B valid, bits 5:0 source B. Entry k's issue cycle is at `issue_cyc_o[k*6 +: 6]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Captures the window and the mode, and starts scheduling |
| full_mode_i | input | 1 | 1: RAW, WAR and WAW block; 0: only RAW blocks |
| entries_i | input | DEPTH*22 | Instruction window, entry 0 oldest |
| issue_cyc_o | output | DEPTH*CYC_W | Issue cycle per entry; 0 means not issued or invalid |
| done_o | output | 1 | All valid entries have been issued |

## Verification
Suppose an executed flag is lost or set too early. An entry then either issues a second time with a later number, or issues before its producer. Either error shows in `issue_cyc_o` at the edge where it happens, and stays visible once `done_o` rises. A cycle counter that is off by one shifts every later issue number, and it also moves the `done_o` edge away from the largest reported cycle. So checking the whole issue vector together with the latency to `done_o` catches such faults within the same run. A wrong pair comparator only shows up on a pattern that contains that hazard kind, in that mode. For this reason every kind is driven in both modes.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;
  parameter int unsigned REG_W = 6;

  typedef logic [REG_W-1:0] reg_idx_t;

  typedef struct packed {
    logic     valid;
    logic     dst_v;
    reg_idx_t dst;
    logic     src_a_v;
    reg_idx_t src_a;
    logic     src_b_v;
    reg_idx_t src_b;
  } sched_entry_t;

  localparam int unsigned ENTRY_W = $bits(sched_entry_t);
endpackage

// File: rtl/sched_hazard_pair.sv
`timescale 1ns/1ps
module sched_hazard_pair
  import sched_pkg::*;
(
  input  sched_entry_t older_i,
  input  sched_entry_t younger_i,
  input  logic         full_mode_i,
  output logic         block_o
);
  function automatic logic reads(input logic v, input reg_idx_t r, input reg_idx_t tgt);
    return v && (r == tgt) && (r != '0);
  endfunction

  logic old_wr, yng_wr, raw, war, waw;

  always_comb begin
    old_wr = older_i.dst_v && (older_i.dst != '0);
    yng_wr = younger_i.dst_v && (younger_i.dst != '0);
    raw = old_wr && (reads(younger_i.src_a_v, younger_i.src_a, older_i.dst) ||
                     reads(younger_i.src_b_v, younger_i.src_b, older_i.dst));
    war = yng_wr && (reads(older_i.src_a_v, older_i.src_a, younger_i.dst) ||
                     reads(older_i.src_b_v, older_i.src_b, younger_i.dst));
    waw = old_wr && yng_wr && (older_i.dst == younger_i.dst);
    block_o = raw || (full_mode_i && (war || waw));
  end
endmodule

// File: rtl/sched_ready_matrix.sv
`timescale 1ns/1ps
module sched_ready_matrix
  import sched_pkg::*;
#(
  parameter int unsigned DEPTH = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  sched_entry_t       entries_i [DEPTH],
  input  logic [DEPTH-1:0]   pending_i,
  input  logic               full_mode_i,
  output logic [DEPTH-1:0]   ready_o
);
  logic [DEPTH-1:0] blk [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
    for (genvar gj = 0; gj < DEPTH; gj++) begin : g_col
      if (gj < gi) begin : g_pair
        sched_hazard_pair u_pair (
          .older_i     (entries_i[gj]),
          .younger_i   (entries_i[gi]),
          .full_mode_i (full_mode_i),
          .block_o     (blk[gi][gj])
        );
      end else begin : g_none
        assign blk[gi][gj] = 1'b0;
      end
    end
    // only older entries still pending at the start of the cycle count
    assign ready_o[gi] = pending_i[gi] & ~|(blk[gi] & pending_i);
  end

  logic [DEPTH-1:0] oldest;
  assign oldest = pending_i & (~pending_i + {{(DEPTH-1){1'b0}}, 1'b1});

  // R11: the oldest pending entry has no pending elder, so it can always issue
  a_r11_oldest_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_i != '0) |-> ((ready_o & oldest) != '0));
endmodule

// File: rtl/sched_issue_window.sv
`timescale 1ns/1ps
module sched_issue_window
  import sched_pkg::*;
#(
  parameter  int unsigned DEPTH = 32,
  localparam int unsigned CYC_W = $clog2(DEPTH + 2)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     full_mode_i,
  input  logic [DEPTH*ENTRY_W-1:0] entries_i,
  output logic [DEPTH*CYC_W-1:0]   issue_cyc_o,
  output logic                     done_o
);
  sched_entry_t     win_in [DEPTH];
  sched_entry_t     win_q  [DEPTH];
  logic [CYC_W-1:0] issue_q [DEPTH];
  logic [CYC_W-1:0] cyc_q;
  logic [DEPTH-1:0] exec_q, valid_vec, pending, ready;
  logic             full_q, loaded_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign win_in[g]                       = entries_i[g*ENTRY_W +: ENTRY_W];
    assign valid_vec[g]                    = win_q[g].valid;
    assign issue_cyc_o[g*CYC_W +: CYC_W]   = issue_q[g];
  end

  assign pending = valid_vec & ~exec_q;
  assign done_o  = loaded_q && (pending == '0);

  sched_ready_matrix #(.DEPTH(DEPTH)) u_ready (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .entries_i   (win_q),
    .pending_i   (pending),
    .full_mode_i (full_q),
    .ready_o     (ready)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      full_q   <= 1'b0;
      exec_q   <= '0;
      cyc_q    <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        win_q[i]   <= '0;
        issue_q[i] <= '0;
      end
    end else if (start_i) begin
      loaded_q <= 1'b1;
      full_q   <= full_mode_i;
      exec_q   <= '0;
      cyc_q    <= {{(CYC_W-1){1'b0}}, 1'b1};
      for (int i = 0; i < DEPTH; i++) begin
        win_q[i]   <= win_in[i];
        issue_q[i] <= '0;
      end
    end else if (loaded_q && (pending != '0)) begin
      exec_q <= exec_q | ready;
      cyc_q  <= cyc_q + 1'b1;
      for (int i = 0; i < DEPTH; i++)
        if (ready[i]) issue_q[i] <= cyc_q;
    end
  end

  // R11: executed flags never drop between starts
  a_r11_exec_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ((exec_q & $past(exec_q)) == $past(exec_q)));

  // R2: while work remains, every cycle issues at least one entry
  a_r2_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded_q && (pending != '0) && !start_i) |=> (exec_q != $past(exec_q)));

  // R9: completed schedule is frozen until the next start
  a_r9_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(issue_cyc_o)));

  // R10: a schedule never needs more cycles than entries
  a_r10_cycle_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |-> (cyc_q <= CYC_W'(DEPTH + 1)));
endmodule

// File: tb/sim_sched_issue_window.sv
`timescale 1ns/1ps
module sim_sched_issue_window;
  localparam int DEPTH = 32;
  localparam int EW    = 22;
  localparam int CW    = 6;
  localparam int NROW  = 10;
  localparam int NLP   = 28;

  function automatic logic [EW-1:0] entf(input int dv, input int d, input int av,
                                         input int a, input int bv, input int b);
    logic [5:0] d6, a6, b6;
    d6 = d[5:0]; a6 = a[5:0]; b6 = b[5:0];
    return {1'b1, (dv != 0), d6, (av != 0), a6, (bv != 0), b6};
  endfunction

  function automatic logic [EW-1:0] ent(input int d, input int a, input int b);
    return entf(int'(d >= 0), d, int'(a >= 0), a, int'(b >= 0), b);
  endfunction

  localparam logic [EW-1:0] R_ENT [NROW][4] = '{
    '{ent(1,2,3),  ent(4,5,6),  ent(7,8,9),  ent(10,-1,-1)},
    '{ent(1,-1,-1), ent(2,1,-1), ent(3,-1,2), ent(4,3,1)},
    '{ent(1,2,-1), ent(2,-1,-1), ent(5,-1,-1), ent(6,-1,-1)},
    '{ent(1,2,-1), ent(2,-1,-1), ent(5,-1,-1), ent(6,-1,-1)},
    '{ent(3,-1,-1), ent(3,4,-1), ent(5,3,-1), ent(7,-1,-1)},
    '{ent(3,-1,-1), ent(3,4,-1), ent(5,3,-1), ent(7,-1,-1)},
    '{ent(0,1,-1), ent(2,0,0), ent(0,-1,-1), ent(3,0,-1)},
    '{entf(0,5,1,1,0,5), ent(6,5,-1), ent(1,-1,-1), ent(9,-1,-1)},
    '{ent(1,-1,-1), 22'h1FFFFF, ent(2,63,-1), ent(3,1,-1)},
    '{ent(1,-1,-1), ent(2,1,-1), ent(3,1,-1), ent(4,2,3)}
  };
  localparam int R_EXP [NROW][4] = '{
    '{1,1,1,1}, '{1,2,3,4}, '{1,2,1,1}, '{1,1,1,1}, '{1,2,3,1},
    '{1,1,2,1}, '{1,1,1,1}, '{1,1,2,1}, '{1,0,1,2}, '{1,2,2,3}
  };
  localparam bit R_FULL [NROW] = '{1,1,1,0,1,0,1,1,1,0};

  // two-tap-per-stage filter sequence; 32 = implicit multiply result register
  localparam logic [EW-1:0] LP [NLP] = '{
    ent(12,-1,-1), ent(16,0,-1), ent(13,16,-1), ent(16,16,-1), ent(14,16,-1),
    ent(15,13,14), ent(32,15,12), ent(15,32,-1), ent(15,15,14), ent(-1,15,16),
    ent(13,14,-1), ent(16,16,-1), ent(14,16,-1),
    ent(15,13,14), ent(32,15,12), ent(15,32,-1), ent(15,15,14), ent(-1,15,16),
    ent(13,14,-1), ent(16,16,-1), ent(14,16,-1),
    ent(15,13,14), ent(32,15,12), ent(15,32,-1), ent(15,15,14), ent(-1,15,16),
    ent(32,15,4), ent(2,32,-1)
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic full_mode = 1'b0;
  logic [DEPTH*EW-1:0] entries;
  logic [DEPTH*CW-1:0] issue_cyc;
  logic done;
  logic [EW-1:0] win [DEPTH];
  int exp_arr [DEPTH];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < DEPTH; i++) entries[i*EW +: EW] = win[i];

  sched_issue_window #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .full_mode_i(full_mode),
    .entries_i(entries), .issue_cyc_o(issue_cyc), .done_o(done)
  );

  function automatic int cyc_of(input int i);
    return int'(issue_cyc[i*CW +: CW]);
  endfunction

  function automatic string row_tag(input int r);
    case (r)
      0: return "R2";  1: return "R3";  2: return "R4";  3: return "R6";
      4: return "R5";  5: return "R6";  6: return "R7";  7: return "R7";
      8: return "R8";  default: return "R11";
    endcase
  endfunction

  function automatic bit blocks(input logic [EW-1:0] o, input logic [EW-1:0] y, input bit full);
    bit od, yd, raw, war, waw;
    od  = o[20] && (o[19:14] != 0);
    yd  = y[20] && (y[19:14] != 0);
    raw = od && ((y[13] && y[12:7] == o[19:14]) || (y[6] && y[5:0] == o[19:14]));
    war = yd && ((o[13] && o[12:7] == y[19:14] && o[12:7] != 0) ||
                 (o[6] && o[5:0] == y[19:14] && o[5:0] != 0));
    waw = od && yd && (o[19:14] == y[19:14]);
    return raw || (full && (war || waw));
  endfunction

  task automatic ref_sched(input bit full);
    bit exd [DEPTH];
    bit rdy [DEPTH];
    bit any;
    int cyc;
    for (int i = 0; i < DEPTH; i++) begin exd[i] = !win[i][21]; exp_arr[i] = 0; end
    cyc = 1;
    any = 1'b1;
    while (any && cyc <= DEPTH + 1) begin
      for (int i = 0; i < DEPTH; i++) begin
        rdy[i] = !exd[i];
        for (int j = 0; j < i; j++)
          if (!exd[j] && blocks(win[j], win[i], full)) rdy[i] = 1'b0;
      end
      any = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        if (rdy[i]) begin exd[i] = 1'b1; exp_arr[i] = cyc; end
        if (!exd[i]) any = 1'b1;
      end
      cyc++;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input bit full);
    @(negedge clk);
    full_mode = full;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    full_mode = ~full;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < DEPTH + 4) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int n, mx, keep;
    for (int i = 0; i < DEPTH; i++) win[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset done", int'(done), 0);
    chk("R1", "reset issue sum", int'(|issue_cyc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle done", int'(done), 0);

    for (int r = 0; r < NROW; r++) begin
      for (int i = 0; i < DEPTH; i++) win[i] = (i < 4) ? R_ENT[r][i] : '0;
      launch(R_FULL[r]);
      chk("R1", "done after load", int'(done), 0);
      chk("R1", "issue cleared", int'(|issue_cyc), 0);
      wait_done(n);
      mx = 0;
      for (int i = 0; i < 4; i++) if (R_EXP[r][i] > mx) mx = R_EXP[r][i];
      chk("R10", $sformatf("row %0d latency", r), n, mx);
      for (int i = 0; i < 4; i++)
        chk(row_tag(r), $sformatf("row %0d entry %0d", r, i), cyc_of(i), R_EXP[r][i]);
      for (int i = 4; i < DEPTH; i++)
        chk("R8", $sformatf("row %0d empty slot %0d", r, i), cyc_of(i), 0);
    end

    // R9: done and results hold while start stays low
    keep = cyc_of(3);
    repeat (5) @(negedge clk);
    chk("R9", "done held", int'(done), 1);
    chk("R9", "result held", cyc_of(3), keep);

    // R10/R8: empty window completes at once
    for (int i = 0; i < DEPTH; i++) win[i] = '0;
    launch(1'b1);
    chk("R10", "empty window done", int'(done), 1);

    // R3/R10: full-length chain, boundary of the cycle count
    for (int i = 0; i < DEPTH; i++) win[i] = ent(i + 1, i, -1);
    launch(1'b0);
    wait_done(n);
    chk("R10", "chain latency", n, DEPTH);
    for (int i = 0; i < DEPTH; i++)
      chk("R3", $sformatf("chain entry %0d", i), cyc_of(i), i + 1);

    // R12 field layout, R4/R5/R6: filter sequence in both modes
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < DEPTH; i++) win[i] = (i < NLP) ? LP[i] : '0;
      ref_sched(m == 1);
      launch(m == 1);
      wait_done(n);
      mx = 0;
      for (int i = 0; i < DEPTH; i++) if (exp_arr[i] > mx) mx = exp_arr[i];
      chk("R10", $sformatf("filter mode %0d latency", m), n, mx);
      for (int i = 0; i < DEPTH; i++)
        chk((m == 1) ? "R12_R4_R5" : "R12_R6", $sformatf("filter mode %0d entry %0d", m, i),
            cyc_of(i), exp_arr[i]);
    end

    // R1: restart mid-schedule clears results
    for (int i = 0; i < DEPTH; i++) win[i] = ent(i + 1, i, -1);
    launch(1'b1);
    repeat (3) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) win[i] = (i < 4) ? R_ENT[1][i] : '0;
    launch(1'b1);
    chk("R1", "restart clears entry 0", cyc_of(0), 0);
    chk("R1", "restart clears entry 2", cyc_of(2), 0);
    wait_done(n);
    chk("R1", "restart latency", n, 4);
    chk("R1", "restart entry 3", cyc_of(3), 4);
    chk("R8", "restart old slot 10", cyc_of(10), 0);

    summary();
  end
endmodule